// File: doc/BRIEF.md
# Flash Read Wait-State Sequencer

This block times one flash read for a bus port and hands the data back after the number of wait cycles the current configuration calls for. When a request is accepted the block can insert a single address-setup cycle, and only after that does it request arbitration. It then holds the flash strobe for a programmed number of extra clocks. In automatic mode it instead waits until an access-complete input from the flash array goes high. Bus ready and data-valid rise together for one clock when the read is finished.

Some requests hit in the read buffer of their port. These hits never touch the flash. Normally a hit comes back at once. Each bus port has a stretch bit that makes its hits take exactly as long as a real flash read, so the requester always sees the same latency. Automatic mode overrides the stretch bits. A stretch bit only takes effect once that port's buffer has been refilled by a flash read. Port identifier `NUM_BUS` stands for the internal checksum engine, which never gets the address-setup cycle. All other timing fields are captured when a request is accepted, so an access already in progress is never retimed.

Top module: `flash_read_timer`

## Requirements
- R1: After reset, `arb_req_o`, `flash_strobe_o`, `data_valid_o` and `bus_ready_o` are all low.
- R2: In manual mode (`auto_ws_i`=0), a read miss from a bus port (id 0..NUM_BUS-1) raises `bus_ready_o` in the 2+A+W-th clock edge counting the accepting edge as the first. A is `addr_wait_i` and W is `access_ws_i` (0..15).
- R3: When `addr_wait_i`=1 for a bus port, `arb_req_o` pulses once, one cycle later than without setup. The pulse comes in the first cycle after the setup cycle. `flash_strobe_o` stays low during the setup cycle.
- R4: Requests from id NUM_BUS (the checksum engine) never get the setup cycle. A miss takes 2+W edges whatever `addr_wait_i` is.
- R5: In automatic mode a miss ignores `access_ws_i`. It completes on the edge after the first edge at which `flash_rdy_i` is sampled high during the access phase.
- R6: A buffer hit (`hit_i`=1) whose port stretch bit is clear returns on the accepting edge (latency 1). It never raises `flash_strobe_o` or `arb_req_o`.
- R7: A buffer hit on a bus port whose active stretch bit is set returns with the manual-miss latency 2+A+W. It raises neither `flash_strobe_o` nor `arb_req_o`.
- R8: In automatic mode every buffer hit returns with latency 1, whatever the stretch bits are.
- R9: `buf_ws_i[n]` becomes the active stretch bit of port n only when a flash read miss on port n completes. At reset all active stretch bits are 0.
- R10: Changes to `access_ws_i` or `addr_wait_i` after the accepting edge do not change the latency of the access in progress.
- R11: `bus_ready_o` and `data_valid_o` are high together for exactly one cycle per access and low during the wait count.
- R12: A request raised while an access is in progress is ignored. No extra ready pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Read request, accepted only when idle |
| port_i | input | $clog2(NUM_BUS+1) | Requester id; NUM_BUS is the internal checksum engine |
| hit_i | input | 1 | Request hits the port's read buffer |
| addr_wait_i | input | 1 | Add one address-setup cycle for bus ports |
| access_ws_i | input | WS_W | Extra access clocks in manual mode |
| auto_ws_i | input | 1 | Automatic mode: wait for flash_rdy_i |
| buf_ws_i | input | NUM_BUS | Per-port stretch bits for buffer hits |
| flash_rdy_i | input | 1 | Access complete from the flash array (automatic mode) |
| arb_req_o | output | 1 | One-cycle arbitration request for a flash read |
| flash_strobe_o | output | 1 | Flash access in progress |
| data_valid_o | output | 1 | Read data valid |
| bus_ready_o | output | 1 | Bus transfer complete |

## Verification
The bench uses the defaults NUM_BUS=4 and WS_W=4. This keeps every wait value 0..15, both setup settings and all five requester ids small enough to sweep in full for misses. The automatic-mode ready delay is swept over several values for one bus port and for the checksum engine. The small port count lets the bench drive each stretch bit through its whole life: set, not yet active, activated by a miss, overridden by automatic mode, then cleared by a later miss. Every access also rewrites the timing inputs and raises a stray request while it is in progress.

// File: rtl/frt_pkg.sv
// Shared types for the flash read wait-state sequencer.
// Assumes: encodings are internal; nothing outside the block decodes them.
package frt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2,
        ST_DONE   = 2'd3
    } frt_state_e;
endpackage

// File: rtl/frt_wait_cnt.sv
// Down-counter for the programmed access wait.
// Loads a value, decrements on request and flags zero.
// Assumes: load and dec never occur in the same cycle.
module frt_wait_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    // Count register: load wins, otherwise decrement until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (load_i)               cnt_q <= load_val_i;
        else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // Zero flag used by the sequencer to end the wait.
    always_comb zero_o = (cnt_q == '0);

    // R10
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i)));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/frt_buf_shadow.sv
// Per-port active stretch bits for read-buffer hits.
// Bit n copies its configuration bit only when port n's buffer is refilled.
// Assumes: upd_port_i is below N whenever upd_i is high.
module frt_buf_shadow #(
    parameter int N  = 4,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_i,
    input  logic [PW-1:0] upd_port_i,
    input  logic [N-1:0]  cfg_i,
    output logic [N-1:0]  stretch_o
);
    for (genvar g = 0; g < N; g++) begin : g_port
        // Shadow flop for port g, refreshed on that port's buffer update.
        always_ff @(posedge clk) begin
            if (!rst_n)                                stretch_o[g] <= 1'b0;
            else if (upd_i && upd_port_i == PW'(g))    stretch_o[g] <= cfg_i[g];
        end
    end

    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(stretch_o));
endmodule

// File: rtl/flash_read_timer.sv
// Flash read wait-state sequencer.
// Accepts one request at a time.
// Optionally inserts an address-setup cycle for bus ports.
// Times the access either from a programmed wait count or from a ready input.
// Returns the data with a one-cycle ready/valid pulse.
// Buffer hits skip the flash and may be stretched per port to the flash latency.
// Assumes: the arbitration grant is immediate; port_i == NUM_BUS is the internal engine.
module flash_read_timer
    import frt_pkg::*;
#(
    parameter int NUM_BUS = 4,
    parameter int WS_W    = 4,
    localparam int PORT_W = $clog2(NUM_BUS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [PORT_W-1:0] port_i,
    input  logic              hit_i,
    input  logic              addr_wait_i,
    input  logic [WS_W-1:0]   access_ws_i,
    input  logic              auto_ws_i,
    input  logic [NUM_BUS-1:0] buf_ws_i,
    input  logic              flash_rdy_i,
    output logic              arb_req_o,
    output logic              flash_strobe_o,
    output logic              data_valid_o,
    output logic              bus_ready_o
);
    localparam logic [PORT_W-1:0] CRC_ID = PORT_W'(NUM_BUS);

    frt_state_e        state_q, state_d;
    logic [PORT_W-1:0] port_q;
    logic              real_q;
    logic              auto_q;
    logic              first_q;
    logic              accept;
    logic              in_is_bus;
    logic              q_is_bus;
    logic              sel_stretch;
    logic              do_stretch;
    logic              cnt_zero;
    logic              finish;
    logic              shadow_upd;
    logic [NUM_BUS-1:0] stretch;

    // Request acceptance and classification of the incoming request.
    always_comb begin
        accept      = (state_q == ST_IDLE) && req_i;
        in_is_bus   = (port_i < CRC_ID);
        q_is_bus    = (port_q < CRC_ID);
        sel_stretch = 1'b0;
        for (int i = 0; i < NUM_BUS; i++) begin
            if (port_i == PORT_W'(i)) sel_stretch = stretch[i];
        end
        do_stretch  = hit_i && in_is_bus && !auto_ws_i && sel_stretch;
    end

    // End of the access phase: ready input in automatic mode, else the count.
    always_comb finish = (auto_q && real_q) ? flash_rdy_i : cnt_zero;

    // Next-state logic of the sequencer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (hit_i && !do_stretch)          state_d = ST_DONE;
                    else if (addr_wait_i && in_is_bus) state_d = ST_SETUP;
                    else                               state_d = ST_ACCESS;
                end
            end
            ST_SETUP:  state_d = ST_ACCESS;
            ST_ACCESS: if (finish) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Per-access shadow of requester, access kind and mode, captured on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
            real_q <= 1'b0;
            auto_q <= 1'b0;
        end else if (accept) begin
            port_q <= port_i;
            real_q <= !hit_i;
            auto_q <= auto_ws_i;
        end
    end

    // Marks the first cycle of the access phase for the arbitration pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) first_q <= 1'b0;
        else        first_q <= (state_d == ST_ACCESS) && (state_q != ST_ACCESS);
    end

    // Output decode from the registered state.
    always_comb begin
        arb_req_o      = (state_q == ST_ACCESS) && first_q && real_q;
        flash_strobe_o = (state_q == ST_ACCESS) && real_q;
        data_valid_o   = (state_q == ST_DONE);
        bus_ready_o    = (state_q == ST_DONE);
        shadow_upd     = (state_q == ST_DONE) && real_q && q_is_bus;
    end

    frt_wait_cnt #(
        .W (WS_W)
    ) u_wait_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i (access_ws_i),
        .dec_i      (state_q == ST_ACCESS),
        .zero_o     (cnt_zero)
    );

    frt_buf_shadow #(
        .N  (NUM_BUS),
        .PW (PORT_W)
    ) u_buf_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_i      (shadow_upd),
        .upd_port_i (port_q),
        .cfg_i      (buf_ws_i),
        .stretch_o  (stretch)
    );

    // R11
    rdy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready_o |=> !bus_ready_o);

    // R3
    setup_then_arb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP && real_q) |=> arb_req_o);

    // R4
    crc_no_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP) |-> (port_q != CRC_ID));

    // R12
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(port_q));
endmodule

// File: tb/flash_read_timer_tb_top.sv
// Sweep bench for the flash read wait-state sequencer.
// Latencies come from the requirement formulas.
module flash_read_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int PW = $clog2(NB + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic [PW-1:0] port_i = '0;
    logic          hit_i = 1'b0;
    logic          addr_wait_i = 1'b0;
    logic [3:0]    access_ws_i = '0;
    logic          auto_ws_i = 1'b0;
    logic [NB-1:0] buf_ws_i = '0;
    logic          flash_rdy_i = 1'b0;
    logic          arb_req_o, flash_strobe_o, data_valid_o, bus_ready_o;

    int checks = 0;
    int errors = 0;
    bit sh_m [NB];

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_read_timer #(.NUM_BUS(NB), .WS_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .port_i(port_i), .hit_i(hit_i),
        .addr_wait_i(addr_wait_i), .access_ws_i(access_ws_i), .auto_ws_i(auto_ws_i),
        .buf_ws_i(buf_ws_i), .flash_rdy_i(flash_rdy_i), .arb_req_o(arb_req_o),
        .flash_strobe_o(flash_strobe_o), .data_valid_o(data_valid_o),
        .bus_ready_o(bus_ready_o)
    );

    task automatic check(input bit ok, input string rq, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, expv);
        end
    endtask

    // One access; expected latency from the requirement formulas.
    task automatic run(input int port, input bit hit, input bit aw, input int ws,
                       input bit au, input int d, input string rq);
        int n = 1;
        int expv;
        int arb_n = 0;
        int arb_cnt = 0;
        bit strobe_seen = 1'b0;
        bit is_bus = (port < NB);
        bit stretch = hit && is_bus && !au && sh_m[port];
        bit awe = aw && is_bus;
        if (hit && !stretch) expv = 1;
        else expv = 2 + int'(awe) + ((au && !hit) ? d : ws);
        @(negedge clk);
        port_i = PW'(port); hit_i = hit; addr_wait_i = aw;
        access_ws_i = 4'(ws); auto_ws_i = au; flash_rdy_i = 1'b0; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        access_ws_i = ~4'(ws);
        addr_wait_i = ~aw;
        while (n < 40 && !bus_ready_o) begin
            if (arb_req_o) begin arb_cnt++; arb_n = n; end
            if (flash_strobe_o) strobe_seen = 1'b1;
            req_i = (n == 1);
            if (n == 1) port_i = PW'((port + 1) % (NB + 1));
            flash_rdy_i = au && (n >= int'(awe) + d + 1);
            @(negedge clk);
            n++;
        end
        req_i = 1'b0;
        check(n == expv, {rq, " latency"}, n, expv);
        check(data_valid_o == 1'b1, "R11 valid with ready", int'(data_valid_o), 1);
        check(strobe_seen == !hit, {rq, " strobe usage"}, int'(strobe_seen), int'(!hit));
        check(arb_cnt == int'(!hit), "R3 arbitration count", arb_cnt, int'(!hit));
        if (!hit)
            check(arb_n == 1 + int'(awe), "R3 arbitration timing", arb_n, 1 + int'(awe));
        @(negedge clk);
        check(!bus_ready_o && !data_valid_o, "R12 no extra ready", int'(bus_ready_o), 0);
        flash_rdy_i = 1'b0;
        addr_wait_i = 1'b0;
        if (!hit && is_bus) sh_m[port] = buf_ws_i[port];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) sh_m[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(!arb_req_o && !flash_strobe_o && !data_valid_o && !bus_ready_o,
              "R1 reset outputs", int'(bus_ready_o), 0);
        // R2, R3, R4, R10: manual misses, all ports, setup and wait values
        for (int p = 0; p <= NB; p++)
            for (int a = 0; a < 2; a++)
                for (int w = 0; w < 16; w++)
                    run(p, 1'b0, a[0], w, 1'b0, 0, (p == NB) ? "R4" : "R2");
        // R5: automatic misses with varying ready delay
        for (int a = 0; a < 2; a++)
            for (int dd = 0; dd < 6; dd++) begin
                run(1, 1'b0, a[0], 9, 1'b1, dd, "R5");
                run(NB, 1'b0, a[0], 3, 1'b1, dd, "R5");
            end
        // R6: zero-wait hits on every requester
        for (int p = 0; p <= NB; p++) run(p, 1'b1, 1'b1, 7, 1'b0, 0, "R6");
        // R9: stretch bits set but not yet active
        buf_ws_i = '1;
        for (int p = 0; p < NB; p++) run(p, 1'b1, 1'b0, 5, 1'b0, 0, "R9");
        // R9: miss refills buffer, then R7 stretched hits
        for (int p = 0; p < NB; p++) begin
            run(p, 1'b0, 1'b0, 2, 1'b0, 0, "R9");
            for (int w = 0; w < 16; w += 5) begin
                run(p, 1'b1, 1'b0, w, 1'b0, 0, "R7");
                run(p, 1'b1, 1'b1, w, 1'b0, 0, "R7");
            end
            // R8
            run(p, 1'b1, 1'b1, 11, 1'b1, 0, "R8");
        end
        // R9: clearing configuration has no effect until next miss
        buf_ws_i = '0;
        run(2, 1'b1, 1'b0, 6, 1'b0, 0, "R9");
        run(2, 1'b0, 1'b0, 1, 1'b0, 0, "R9");
        run(2, 1'b1, 1'b0, 6, 1'b0, 0, "R9");
        run(3, 1'b1, 1'b1, 4, 1'b0, 0, "R9");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule